// File: doc/BRIEF.md
# Column-Compression Unsigned Multiplier

This block multiplies two unsigned operands of `N` bits (8 by default) and delivers the full `2N`-bit product. Every bit pair of the operands is ANDed to give a matrix of `N*N` dots. Each dot sits in the column that matches its weight. The matrix is then compressed in a fixed number of stages until no column holds more than two dots. A parallel-prefix adder adds the last two rows.

Each compression stage has a height limit. The limits come from a backward series that starts at 2 and grows by a factor of 1.5, with the result rounded down each time. A column gets counters only when its own dots, plus the carries that the lower column sends in during the same stage, would exceed that limit. It then gets only as many counters as are needed to bring it down to the limit. Within a stage the columns are processed from the least significant upward, so the number of incoming carries is known before a column is planned. For 8-bit operands the limits are 6, 4, 3 and 2.

The sum is captured in an output register with a synchronous, active-low reset. A new product therefore appears one clock after its operands are presented.

Top module: `dadda_mul`

## Requirements
- R1: For every pair of unsigned operands, `product` equals `op_a * op_b` as an exact unsigned value of `2N` bits, with no truncation.
- R2: `product` changes only at a rising clock edge, and it holds the result of the operands sampled at the previous edge. A change of operands between edges does not move `product`.
- R3: While `rst_n` is low at a rising edge, `product` becomes all zeros at that edge, whatever the operands are.
- R4: If either operand is zero, the product is zero.
- R5: With both operands at their maximum (255 for N=8), the product is 16'hFE01, which uses the top result bit.
- R6: If one operand is a single power of two, 2^k, the product is the other operand shifted left by k places.
- R7: Every compression stage keeps the weighted value of the matrix unchanged. After the stages for N=8 the column heights are at most 6, 4, 3 and 2 in turn.
- R8: A three-input counter and a two-input counter each produce a sum bit of the same weight and a carry bit of the next weight, and sum + 2*carry equals the number of ones at the inputs.
- R9: The final adder returns the exact sum of the two remaining rows, modulo 2^(2N).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | N | Multiplicand, unsigned |
| op_b | input | N | Multiplier, unsigned |
| product | output | 2N | Registered unsigned product |

## Verification
The clocked checks on the output register assume that the operands are stable at each rising edge and that one full cycle out of reset has passed before a product is compared. The bench meets this by changing operands and reset only on falling edges, and by sampling results on the falling edge after the capture. The combinational checks inside the stages, the counters and the adder assume that all inputs are 0 or 1. The operands are always driven to known values from time zero, including during reset, so no unknown value reaches the tree. The full sweep over all operand pairs drives every dot position through both values.

// File: rtl/dadda_pkg.sv
// dadda_pkg: elaboration-time planning of the column-compression tree.
// Assumes 2*n <= MAX_COLS. All functions are evaluated while parameters
// are resolved; none of them is meant to produce hardware.
package dadda_pkg;

    localparam int MAX_COLS = 64;

    // Query codes for tree_info
    localparam int Q_HEIGHT   = 0;  // dots in a column entering a stage
    localparam int Q_FULL     = 1;  // three-input counters in a column
    localparam int Q_HALF     = 2;  // two-input counters in a column
    localparam int Q_CTR_BASE = 3;  // counters in all lower columns
    localparam int Q_DOT_BASE = 4;  // dots in all lower columns
    localparam int Q_CARRY_IN = 5;  // carries arriving from column-1

    // k-th height of the backward series 2, 3, 4, 6, 9, ...
    function automatic int height_seq(int k);
        int h = 2;
        for (int i = 0; i < k; i++) h = (h * 3) / 2;
        return h;
    endfunction

    // number of stages needed to bring an n-row matrix down to 2 rows
    function automatic int num_stages(int n);
        int s = 0;
        while (height_seq(s) < n) s++;
        return s;
    endfunction

    // height limit of stage st (stage 0 has the largest limit)
    function automatic int stage_target(int n, int st);
        return height_seq(num_stages(n) - 1 - st);
    endfunction

    // Plans stages 0..s column by column from the LSB upward and answers
    // one query about stage s. Stage num_stages(n) is the final matrix.
    function automatic int tree_info(int n, int s, int col, int what);
        int cnt [MAX_COLS];
        int pre [MAX_COLS];
        int nf  [MAX_COLS];
        int nh  [MAX_COLS];
        int cin, ex, lim, res;
        for (int c = 0; c < MAX_COLS; c++) begin
            if (c < n)              cnt[c] = c + 1;
            else if (c < 2 * n - 1) cnt[c] = 2 * n - 1 - c;
            else                    cnt[c] = 0;
            pre[c] = 0;
            nf[c]  = 0;
            nh[c]  = 0;
        end
        for (int st = 0; st <= s; st++) begin
            for (int c = 0; c < MAX_COLS; c++) pre[c] = cnt[c];
            lim = (st < num_stages(n)) ? stage_target(n, st) : MAX_COLS;
            cin = 0;
            for (int c = 0; c < MAX_COLS; c++) begin
                ex = cnt[c] + cin - lim;
                if (ex > 0) begin
                    nf[c] = ex / 2;
                    nh[c] = ex % 2;
                end else begin
                    nf[c] = 0;
                    nh[c] = 0;
                end
                cnt[c] = cnt[c] - 2 * nf[c] - nh[c] + cin;
                cin    = nf[c] + nh[c];
            end
        end
        res = 0;
        case (what)
            Q_HEIGHT:   res = pre[col];
            Q_FULL:     res = nf[col];
            Q_HALF:     res = nh[col];
            Q_CTR_BASE: for (int c = 0; c < col; c++) res += nf[c] + nh[c];
            Q_DOT_BASE: for (int c = 0; c < col; c++) res += pre[c];
            Q_CARRY_IN: res = (col > 0) ? nf[col - 1] + nh[col - 1] : 0;
            default:    res = 0;
        endcase
        return res;
    endfunction

    // total dots entering stage s
    function automatic int dots_total(int n, int s);
        return tree_info(n, s, 2 * n, Q_DOT_BASE);
    endfunction

    // total counters used in stage s
    function automatic int ctr_total(int n, int s);
        return tree_info(n, s, 2 * n, Q_CTR_BASE);
    endfunction

    // offset of stage s's matrix inside the flat bus of all matrices
    function automatic int mat_base(int n, int s);
        int b = 0;
        for (int t = 0; t < s; t++) b += dots_total(n, t);
        return b;
    endfunction

endpackage

// File: rtl/dadda_counter.sv
// dadda_counter: counts the ones on IN (2 or 3) equal-weight dots.
// sum keeps the column weight and carry moves one column up.
// Assumes IN is 2 (half adder) or 3 (full adder).
module dadda_counter #(
    parameter int IN = 3
) (
    input  logic [IN-1:0] bits,
    output logic          sum,
    output logic          carry
);

    assign sum = ^bits;

    generate
        if (IN == 3) begin : g_full
            assign carry = (bits[0] & bits[1]) | (bits[0] & bits[2]) | (bits[1] & bits[2]);
        end else begin : g_half
            assign carry = &bits;
        end
    endgenerate

    // The outputs encode the number of ones at the inputs
    always_comb begin
        p_count_r8: assert ({carry, sum} == 2'($countones(bits)))
            else $error("p_count_r8: counter output does not match input ones");
    end

endmodule

// File: rtl/dadda_stage.sv
// dadda_stage: one compression stage. Brings every column down to the
// stage limit using the plan from dadda_pkg. Each column of the output is
// laid out as untouched dots, then own sums, then carries from below.
// Assumes din is laid out column by column as planned for stage STG.
module dadda_stage import dadda_pkg::*; #(
    parameter int N   = 8,
    parameter int STG = 0
) (
    input  logic [dots_total(N, STG)-1:0]     din,
    output logic [dots_total(N, STG + 1)-1:0] dout
);

    localparam int COLS = 2 * N;
    localparam int NCTR = ctr_total(N, STG);
    localparam int WW   = COLS + 8;

    logic [NCTR-1:0]      ctr_s;
    logic [NCTR-1:0]      ctr_c;
    logic [COLS-1:0][7:0] pop_in;
    logic [COLS-1:0][7:0] pop_out;

    generate
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int H    = tree_info(N, STG, c, Q_HEIGHT);
            localparam int OH   = tree_info(N, STG + 1, c, Q_HEIGHT);
            localparam int NF   = tree_info(N, STG, c, Q_FULL);
            localparam int NH   = tree_info(N, STG, c, Q_HALF);
            localparam int IB   = tree_info(N, STG, c, Q_DOT_BASE);
            localparam int OB   = tree_info(N, STG + 1, c, Q_DOT_BASE);
            localparam int CB   = tree_info(N, STG, c, Q_CTR_BASE);
            localparam int CI   = tree_info(N, STG, c, Q_CARRY_IN);
            localparam int NC   = NF + NH;
            localparam int KEEP = H - 3 * NF - 2 * NH;

            for (genvar k = 0; k < NF; k++) begin : g_fa
                dadda_counter #(.IN(3)) u_fa (
                    .bits  (din[IB + 3 * k +: 3]),
                    .sum   (ctr_s[CB + k]),
                    .carry (ctr_c[CB + k])
                );
            end
            if (NH > 0) begin : g_ha
                dadda_counter #(.IN(2)) u_ha (
                    .bits  (din[IB + 3 * NF +: 2]),
                    .sum   (ctr_s[CB + NF]),
                    .carry (ctr_c[CB + NF])
                );
            end
            if (KEEP > 0) begin : g_keep
                assign dout[OB +: KEEP] = din[IB + 3 * NF + 2 * NH +: KEEP];
            end
            if (NC > 0) begin : g_sum
                assign dout[OB + KEEP +: NC] = ctr_s[CB +: NC];
            end
            if (CI > 0) begin : g_cin
                assign dout[OB + KEEP + NC +: CI] = ctr_c[CB - CI +: CI];
            end

            // Dot counts per column, used only by the value check below
            if (H > 0) begin : g_pin
                assign pop_in[c] = 8'($countones(din[IB +: H]));
            end else begin : g_pin0
                assign pop_in[c] = '0;
            end
            if (OH > 0) begin : g_pout
                assign pop_out[c] = 8'($countones(dout[OB +: OH]));
            end else begin : g_pout0
                assign pop_out[c] = '0;
            end
        end
    endgenerate

    logic [WW-1:0] wt_in;
    logic [WW-1:0] wt_out;

    // Weighted value of the matrix before and after this stage must agree
    always_comb begin
        wt_in  = '0;
        wt_out = '0;
        for (int c = 0; c < COLS; c++) begin
            wt_in  = wt_in  + (WW'(pop_in[c])  << c);
            wt_out = wt_out + (WW'(pop_out[c]) << c);
        end
        p_weight_kept_r7: assert (wt_in == wt_out)
            else $error("p_weight_kept_r7: stage %0d changed matrix value", STG);
    end

endmodule

// File: rtl/dadda_cpa.sv
// dadda_cpa: parallel-prefix carry-propagate adder for the last two rows.
// Log2(W) levels of generate/propagate merging. The carry out of the top
// bit is dropped because the product is known to fit in W bits.
module dadda_cpa #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum
);

    logic [W-1:0] half;
    logic [W-1:0] gen;
    logic [W-1:0] prop;

    // Prefix merge of generate/propagate pairs, then the final XOR
    always_comb begin
        half = x ^ y;
        gen  = x & y;
        prop = half;
        for (int d = 1; d < W; d = d * 2) begin
            gen  = gen | (prop & (gen << d));
            prop = prop & ((prop << d) | ((W'(1) << d) - W'(1)));
        end
        sum = half ^ {gen[W-2:0], 1'b0};
    end

    // The two rows are added exactly
    always_comb begin
        p_cpa_sum_r9: assert (sum == W'(x + y))
            else $error("p_cpa_sum_r9: prefix adder result wrong");
    end

endmodule

// File: rtl/dadda_mul.sv
// dadda_mul: unsigned N x N multiplier. AND array, planned column
// compression down to two rows, prefix adder, optional output register
// (synchronous active-low reset). Assumes operands stable at the clock.
module dadda_mul import dadda_pkg::*; #(
    parameter int N       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic [2*N-1:0] product
);

    localparam int COLS = 2 * N;
    localparam int NSTG = num_stages(N);
    localparam int ALL  = mat_base(N, NSTG + 1);
    localparam int FB   = mat_base(N, NSTG);

    logic [ALL-1:0]  mats;
    logic [COLS-1:0] row_x;
    logic [COLS-1:0] row_y;
    logic [COLS-1:0] sum_c;

    generate
        // Bit products, placed in their weight column
        for (genvar i = 0; i < N; i++) begin : g_pa
            for (genvar j = 0; j < N; j++) begin : g_pb
                localparam int COL = i + j;
                localparam int LO  = (COL - N + 1 > 0) ? COL - N + 1 : 0;
                localparam int PB  = tree_info(N, 0, COL, Q_DOT_BASE);
                assign mats[PB + j - LO] = op_a[i] & op_b[j];
            end
        end

        // Compression stages, each feeding the next
        for (genvar s = 0; s < NSTG; s++) begin : g_stg
            dadda_stage #(.N(N), .STG(s)) u_stage (
                .din  (mats[mat_base(N, s) +: dots_total(N, s)]),
                .dout (mats[mat_base(N, s + 1) +: dots_total(N, s + 1)])
            );
        end

        // Split the final matrix into two rows, padding short columns
        for (genvar c = 0; c < COLS; c++) begin : g_row
            localparam int K = tree_info(N, NSTG, c, Q_HEIGHT);
            localparam int B = tree_info(N, NSTG, c, Q_DOT_BASE);
            if (K > 0) begin : g_x
                assign row_x[c] = mats[FB + B];
            end else begin : g_x0
                assign row_x[c] = 1'b0;
            end
            if (K > 1) begin : g_y
                assign row_y[c] = mats[FB + B + 1];
            end else begin : g_y0
                assign row_y[c] = 1'b0;
            end
        end
    endgenerate

    dadda_cpa #(.W(COLS)) u_cpa (
        .x   (row_x),
        .y   (row_y),
        .sum (sum_c)
    );

    generate
        if (OUT_REG) begin : g_reg
            // Output register with synchronous active-low clear
            always_ff @(posedge clk) begin
                if (!rst_n) product <= '0;
                else        product <= sum_c;
            end

            p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> product == (COLS'($past(op_a)) * COLS'($past(op_b))))
                else $error("p_product_r1: product wrong");

            p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && $past(rst_n) && $stable(op_a) && $stable(op_b)) |=> $stable(product))
                else $error("p_hold_r2: product moved with steady operands");

            p_reset_r3: assert property (@(posedge clk)
                !rst_n |=> product == '0)
                else $error("p_reset_r3: product not cleared by reset");
        end else begin : g_comb
            assign product = sum_c;
        end
    endgenerate

endmodule

// File: tb/test_dadda_mul.sv
`timescale 1ns/1ps
// test_dadda_mul: directed scenarios plus an exhaustive operand sweep.
module test_dadda_mul;

    localparam int N = 8;
    localparam int W = 2 * N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] op_a = '0;
    logic [N-1:0] op_b = '0;
    logic [W-1:0] product;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dadda_mul #(.N(N), .OUT_REG(1'b1)) i_dadda_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_a    (op_a),
        .op_b    (op_b),
        .product (product)
    );

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // present operands on a falling edge, wait until the registered result is visible
    task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b);
        @(negedge clk);
        op_a = a;
        op_b = b;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        op_a  = 8'hFF;
        op_b  = 8'hFF;
        repeat (3) @(negedge clk);
        check("R3 held in reset", product, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 first result after release", product, 16'hFE01);
        apply(8'h5A, 8'h3C);
        check("R3 before mid-run reset", product, 16'h5A * 16'h3C);
        rst_n = 1'b0;
        @(negedge clk);
        check("R3 mid-run reset clears", product, 16'h0000);
        rst_n = 1'b1;
    endtask

    task automatic t_latency();
        apply(8'd3, 8'd5);
        check("R2 settled", product, 16'd15);
        @(negedge clk);
        op_a = 8'd7;
        op_b = 8'd9;
        #1;
        check("R2 no change between edges", product, 16'd15);
        @(negedge clk);
        check("R2 new value after one edge", product, 16'd63);
    endtask

    task automatic t_zero();
        apply(8'h00, 8'hC3);
        check("R4 a zero", product, 16'h0000);
        apply(8'hC3, 8'h00);
        check("R4 b zero", product, 16'h0000);
        apply(8'h00, 8'h00);
        check("R4 both zero", product, 16'h0000);
    endtask

    task automatic t_max();
        apply(8'hFF, 8'hFF);
        check("R5 max times max", product, 16'hFE01);
        apply(8'hFF, 8'h01);
        check("R5 max times one", product, 16'h00FF);
        apply(8'h80, 8'h80);
        check("R5 top bits", product, 16'h4000);
    endtask

    task automatic t_pow2();
        for (int k = 0; k < N; k++) begin
            apply(8'(1 << k), 8'hB7);
            check("R6 a power of two", product, 16'h00B7 << k);
            apply(8'h6D, 8'(1 << k));
            check("R6 b power of two", product, 16'h006D << k);
        end
    endtask

    // all operand pairs; also exercises every stage, counter and the final adder
    task automatic t_sweep();
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                apply(8'(a), 8'(b));
                check("R1 R7 R8 R9 sweep", product, 16'(a) * 16'(b));
            end
        end
    endtask

    initial begin
        t_reset();
        t_latency();
        t_zero();
        t_max();
        t_pow2();
        t_sweep();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule